// File: doc/BRIEF.md
# Quad DAC serial command receiver

This block is the digital slave front end of a four-channel, 12-bit converter. A host drives a serial clock, an active-low frame select and a data line. The block receives 16-bit command words, decodes a channel address and an operation, and keeps two registers per channel: a staged input register and a live output register. It drives the four live codes and a power-down flag that the analog section uses.

All serial inputs are re-timed into the system clock domain and oversampled there. A falling edge of the serial clock is detected on the system clock, and a bit is taken only while the frame select is low. A command acts only when a full word has arrived. If the frame select rises early, nothing in the block changes.

Top module: `qdac_cmd_rx`

## Requirements
- R1: After synchronous reset every output code is 0 and `dac_pd` is 0.
- R2: A word is 16 bits, taken one per falling edge of `ser_clk` while `ser_sync_n` is low, first bit is the MSB. Bits [15:14] are the channel address (00 = channel 0, 01 = 1, 10 = 2, 11 = 3), bits [13:12] the operation, bits [11:0] the data. Channel n's code is `dac_codes[12n+11:12n]`.
- R3: Operation 00 stores the data in the addressed input register, leaves all output codes unchanged and clears `dac_pd`.
- R4: Operation 01 stores the data in the addressed input register and then copies all four input registers to the output codes. It clears `dac_pd`.
- R5: Operation 10 stores the data in all four input registers and all four output codes. It clears `dac_pd`.
- R6: Operation 11 sets `dac_pd` and changes neither input registers nor output codes.
- R7: If `ser_sync_n` rises before the 16th falling edge, no input register, output code or `dac_pd` changes.
- R8: Falling edges after the 16th in one low period of `ser_sync_n` are ignored until it goes high again.
- R9: A high level on `ser_sync_n` restarts the bit count, so a complete word that follows an aborted one decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, bit taken on its falling edge |
| ser_sync_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data, MSB first |
| dac_codes | output | 48 | Four 12-bit live codes, channel 0 in the low bits |
| dac_pd | output | 1 | Power-down flag |

## Verification
The assertions assume that the serial pins change much more slowly than the system clock. Each level must last several system cycles, so one serial falling edge gives exactly one detected edge, and data is stable across that edge. The bench holds every serial phase for five system clocks. It changes data only while the serial clock is high, and it moves the frame select only while the serial clock is high. As a result, no edge is ever split or merged by the re-timing stages.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  typedef enum logic [1:0] {
    OP_LOAD     = 2'b00,
    OP_LOAD_UPD = 2'b01,
    OP_BCAST    = 2'b10,
    OP_PDOWN    = 2'b11
  } qdac_op_e;
endpackage

// File: rtl/qdac_sync_in.sv
module qdac_sync_in #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx #(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk_s,
  input  logic                  sync_n_s,
  input  logic                  din_s,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  frame_vld_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic                  sclk_q;
  logic                  fall;
  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] shreg_q;
  logic [FRAME_BITS-1:0] shreg_nxt;

  assign fall      = sclk_q & ~sclk_s;
  assign shreg_nxt = {shreg_q[FRAME_BITS-2:0], din_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q      <= 1'b1;
      cnt_q       <= '0;
      shreg_q     <= '0;
      frame_o     <= '0;
      frame_vld_o <= 1'b0;
    end else begin
      sclk_q      <= sclk_s;
      frame_vld_o <= 1'b0;
      if (sync_n_s) begin
        cnt_q <= '0;
      end else if (fall && (cnt_q < FULL)) begin
        shreg_q <= shreg_nxt;
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          frame_o     <= shreg_nxt;
          frame_vld_o <= 1'b1;
        end
      end
    end
  end

  // R7: no word completes out of a cycle in which the select is high
  a_r7_no_done_when_deselected: assert property (@(posedge clk) disable iff (rst)
    sync_n_s |=> !frame_vld_o);
  // R8: the bit count saturates at one full word
  a_r8_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL);
  // R8: a completed word is never followed at once by another
  a_r8_single_done: assert property (@(posedge clk) disable iff (rst)
    frame_vld_o |=> !frame_vld_o);
  // R9: a deselect always leaves the count at zero
  a_r9_count_restart: assert property (@(posedge clk) disable iff (rst)
    sync_n_s |=> cnt_q == '0);
endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
  import qdac_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DATA_W = 12,
  parameter int ADDR_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_vld,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  qdac_op_e              cmd_op,
  input  logic [DATA_W-1:0]     cmd_data,
  output logic [NCH*DATA_W-1:0] codes_o,
  output logic                  pd_o
);
  logic [DATA_W-1:0] in_q  [NCH];
  logic [DATA_W-1:0] out_q [NCH];
  logic              do_upd;

  assign do_upd = cmd_vld && (cmd_op == OP_LOAD_UPD || cmd_op == OP_BCAST);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic              wr_sel;
    logic [DATA_W-1:0] in_nxt;

    assign wr_sel = cmd_vld &&
                    ((cmd_op == OP_BCAST) ||
                     ((cmd_op == OP_LOAD || cmd_op == OP_LOAD_UPD) &&
                      cmd_addr == ADDR_W'(g)));
    assign in_nxt = wr_sel ? cmd_data : in_q[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        in_q[g]  <= '0;
        out_q[g] <= '0;
      end else begin
        if (wr_sel) in_q[g]  <= cmd_data;
        if (do_upd) out_q[g] <= in_nxt;
      end
    end

    assign codes_o[g*DATA_W +: DATA_W] = out_q[g];

    // R5: broadcast lands in every live code one cycle later
    a_r5_bcast_reaches_all: assert property (@(posedge clk) disable iff (rst)
      (cmd_vld && cmd_op == OP_BCAST) |=> out_q[g] == $past(cmd_data));
  end

  always_ff @(posedge clk) begin
    if (rst)          pd_o <= 1'b0;
    else if (cmd_vld) pd_o <= (cmd_op == OP_PDOWN);
  end

  // R3: staging-only write leaves live codes alone and wakes the outputs
  a_r3_load_keeps_codes: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd_op == OP_LOAD) |=> ($stable(codes_o) && !pd_o));
  // R4: write-and-update wakes the outputs
  a_r4_update_wakes: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd_op == OP_LOAD_UPD) |=> !pd_o);
  // R6: power-down raises the flag and freezes the codes
  a_r6_pdown_freezes: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd_op == OP_PDOWN) |=> (pd_o && $stable(codes_o)));
  // R7: without a completed word nothing visible moves
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !cmd_vld |=> ($stable(codes_o) && $stable(pd_o)));
endmodule

// File: rtl/qdac_cmd_rx.sv
module qdac_cmd_rx
  import qdac_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ser_clk,
  input  logic                  ser_sync_n,
  input  logic                  ser_din,
  output logic [NCH*DATA_W-1:0] dac_codes,
  output logic                  dac_pd
);
  localparam int ADDR_W     = $clog2(NCH);
  localparam int OP_W       = 2;
  localparam int FRAME_BITS = ADDR_W + OP_W + DATA_W;

  logic [2:0]            pins_s;
  logic [FRAME_BITS-1:0] frame;
  logic                  frame_vld;
  logic [ADDR_W-1:0]     f_addr;
  qdac_op_e              f_op;
  logic [DATA_W-1:0]     f_data;

  qdac_sync_in #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ser_clk, ser_sync_n, ser_din}),
    .sync_o  (pins_s)
  );

  qdac_frame_rx #(.FRAME_BITS(FRAME_BITS)) u_frame (
    .clk         (clk),
    .rst         (rst),
    .sclk_s      (pins_s[2]),
    .sync_n_s    (pins_s[1]),
    .din_s       (pins_s[0]),
    .frame_o     (frame),
    .frame_vld_o (frame_vld)
  );

  assign f_addr = frame[FRAME_BITS-1 -: ADDR_W];
  assign f_op   = qdac_op_e'(frame[DATA_W +: OP_W]);
  assign f_data = frame[DATA_W-1:0];

  qdac_regbank #(.NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .cmd_vld  (frame_vld),
    .cmd_addr (f_addr),
    .cmd_op   (f_op),
    .cmd_data (f_data),
    .codes_o  (dac_codes),
    .pd_o     (dac_pd)
  );
endmodule

// File: tb/qdac_cmd_rx_bench.sv
module qdac_cmd_rx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b1;
  logic        ser_sync_n = 1'b1;
  logic        ser_din = 1'b0;
  logic [47:0] dac_codes;
  logic        dac_pd;

  int checks = 0;
  int errors = 0;
  logic [11:0] exp_in  [4];
  logic [11:0] exp_out [4];
  logic        exp_pd;

  always #10 clk = ~clk;

  qdac_cmd_rx u_qdac_cmd_rx (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_sync_n(ser_sync_n),
    .ser_din(ser_din), .dac_codes(dac_codes), .dac_pd(dac_pd)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model(input logic [1:0] a, input logic [1:0] op, input logic [11:0] d);
    case (op)
      2'b00: begin exp_in[a] = d; exp_pd = 1'b0; end
      2'b01: begin exp_in[a] = d; for (int i = 0; i < 4; i++) exp_out[i] = exp_in[i]; exp_pd = 1'b0; end
      2'b10: begin for (int i = 0; i < 4; i++) begin exp_in[i] = d; exp_out[i] = d; end exp_pd = 1'b0; end
      default: exp_pd = 1'b1;
    endcase
  endtask

  // sends nedges falling edges; edges beyond 16 carry ones
  task automatic send(input logic [1:0] a, input logic [1:0] op, input logic [11:0] d,
                      input int nedges);
    logic [15:0] w;
    w = {a, op, d};
    ser_clk = 1'b1;
    ser_sync_n = 1'b0;
    wait_clk(5);
    for (int i = 0; i < nedges; i++) begin
      ser_clk = 1'b1;
      ser_din = (i < 16) ? w[15-i] : 1'b1;
      wait_clk(5);
      ser_clk = 1'b0;
      wait_clk(5);
    end
    ser_clk = 1'b1;
    wait_clk(5);
    ser_sync_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 4; i++) begin
      checks++;
      if (dac_codes[i*12 +: 12] !== exp_out[i]) begin
        errors++;
        $display("FAIL %s channel %0d code actual=%h expected=%h", req, i,
                 dac_codes[i*12 +: 12], exp_out[i]);
      end
    end
    checks++;
    if (dac_pd !== exp_pd) begin
      errors++;
      $display("FAIL %s power-down actual=%b expected=%b", req, dac_pd, exp_pd);
    end
  endtask

  task automatic t_reset;
    check_all("R1 reset");
  endtask

  task automatic t_load_only;
    send(2'b00, 2'b00, 12'hA51, 16); model(2'b00, 2'b00, 12'hA51);
    check_all("R3 load only");
    send(2'b10, 2'b00, 12'h3C7, 16); model(2'b10, 2'b00, 12'h3C7);
    check_all("R3 load only second");
  endtask

  task automatic t_load_update;
    send(2'b01, 2'b01, 12'h812, 16); model(2'b01, 2'b01, 12'h812);
    check_all("R4 load and update (R2 field order)");
    send(2'b11, 2'b01, 12'h0F1, 16); model(2'b11, 2'b01, 12'h0F1);
    check_all("R4 load and update channel 3");
  endtask

  task automatic t_broadcast;
    send(2'b10, 2'b10, 12'h5E9, 16); model(2'b10, 2'b10, 12'h5E9);
    check_all("R5 broadcast");
  endtask

  task automatic t_pdown;
    send(2'b00, 2'b11, 12'hFFF, 16); model(2'b00, 2'b11, 12'hFFF);
    check_all("R6 power-down");
    send(2'b01, 2'b00, 12'h123, 16); model(2'b01, 2'b00, 12'h123);
    check_all("R3 load clears power-down");
    send(2'b00, 2'b11, 12'h000, 16); model(2'b00, 2'b11, 12'h000);
    send(2'b00, 2'b01, 12'h456, 16); model(2'b00, 2'b01, 12'h456);
    check_all("R4 update clears power-down, staged channel 1 appears");
  endtask

  task automatic t_abort;
    send(2'b10, 2'b00, 12'hBAD, 9);
    check_all("R7 aborted load");
    send(2'b00, 2'b11, 12'h000, 3);
    check_all("R7 aborted power-down");
    send(2'b00, 2'b10, 12'hEEE, 15);
    check_all("R7 aborted broadcast at 15 edges");
    send(2'b11, 2'b01, 12'h777, 16); model(2'b11, 2'b01, 12'h777);
    check_all("R9 full word after abort, R7 staged channel 2 untouched");
  endtask

  task automatic t_extra_edges;
    send(2'b01, 2'b01, 12'h2A4, 21); model(2'b01, 2'b01, 12'h2A4);
    check_all("R8 extra edges ignored");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin exp_in[i] = '0; exp_out[i] = '0; end
    exp_pd = 1'b0;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(4);
    t_reset();
    t_load_only();
    t_load_update();
    t_broadcast();
    t_pdown();
    t_abort();
    t_extra_edges();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule